// File: doc/BRIEF.md
# Dual-Mode Bit-Serial Shift-Add Accumulator

This block rebuilds a signed 4-bit by 4-bit multiply-accumulate result from the partial sums produced by column converters. Activations arrive one bit per compute cycle, least significant bit first, over four cycles. Each weight bit is stored in its own row. Every converter partial sum counts active cells across 256 input channels.

In precise mode each cycle delivers one partial sum per weight row. The block weights those sums by weight-bit significance to form a per-cycle sum, then accumulates the per-cycle sums by input-bit significance. In efficient mode the rows were already merged in the analog domain before conversion, so each cycle delivers a single 7-bit converter code. That code is first realigned by a per-layer left shift and then goes through the input-bit accumulation level only. In both levels the top weight row and the top input cycle carry negative weight (two's complement).

A start strobe opens an operation and latches the mode and the shift. Four accepted beats then produce a result flagged by a one-cycle valid pulse.

Top module: `sa_dual_acc`

## Requirements
- R1: During and right after reset, `out_valid` and `in_ready` are 0 and `out_result` is 0.
- R2: A cycle with `start` high clears the accumulation and the beat count. `in_ready` is 1 from the next cycle. A beat offered in the start cycle is not taken.
- R3: In precise mode (`mode_sel`=0), the sum for a cycle is p0 + 2*p1 + 4*p2 - 8*p3. Row r of `row_psum` is the unsigned field at bits [9r+8:9r], so row 3 is the top weight bit.
- R4: The sum accepted in beat k (k = 0..3) is scaled by 2^k. The beat-3 term is subtracted; the other three are added.
- R5: In efficient mode (`mode_sel`=1), the sum for a cycle is the unsigned 7-bit `conv_psum` shifted left by `range_shift` (0..7).
- R6: `out_valid` is a one-cycle pulse. It appears in the cycle after the fourth accepted beat, with `out_result` holding the result. In that same cycle `in_ready` is 0.
- R7: A cycle in which `in_valid` is 0 does not advance the beat count or change the accumulation.
- R8: Changes to `mode_sel` and `range_shift` after the start cycle have no effect on the operation in progress.
- R9: A `start` during an operation discards the beats already taken and begins a new operation.
- R10: Extreme inputs give exact results with no wrap. Examples: all rows 511 in every beat; efficient code 127 at shift 7.
- R11: Beats offered while `in_ready` is 0 are ignored. They produce no `out_valid` and leave `out_result` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens an operation and latches configuration |
| mode_sel | input | 1 | 0 = precise (two digital levels), 1 = efficient (one level) |
| range_shift | input | 3 | Left shift applied to efficient-mode codes |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Block is accepting beats |
| row_psum | input | 36 | Four 9-bit row partial sums, row 0 in the low bits |
| conv_psum | input | 7 | Efficient-mode converter code |
| out_valid | output | 1 | Result pulse |
| out_result | output | 19 | Signed accumulated result |

## Verification
A wrong beat count or an accumulator that was not cleared shows up in the cycle right after the fourth beat. The pulse then lands early or late, or `out_result` differs from the arithmetic value. A wrong row or cycle weight, or a missing sign on the top term, shows up on the first operation whose pattern uses that term. The sweeps isolate single rows and single cycles so that each weight is exposed on its own. A configuration register that tracks its input instead of latching it gives a wrong result for the operation in which the pins are flipped mid-flight.

// File: rtl/sa_acc_pkg.sv
package sa_acc_pkg;

    localparam int ROWS     = 4;
    localparam int CYCLES   = 4;
    localparam int PSUM_W   = 9;
    localparam int HE_W     = 7;
    localparam int SHIFT_W  = 3;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // signed width of one cycle sum in each mode
    localparam int HP_SUM_W = PSUM_W + ROWS;
    localparam int HE_SUM_W = HE_W + (1 << SHIFT_W);
    localparam int TERM_W   = imax(HP_SUM_W, HE_SUM_W);
    localparam int ACC_W    = TERM_W + CYCLES;
    localparam int CNT_W    = $clog2(CYCLES);

    typedef enum logic {
        MODE_PRECISE   = 1'b0,
        MODE_EFFICIENT = 1'b1
    } acc_mode_e;

    typedef struct packed {
        acc_mode_e          mode;
        logic [SHIFT_W-1:0] shift;
    } acc_cfg_t;

endpackage

// File: rtl/sa_row_combiner.sv
module sa_row_combiner
    import sa_acc_pkg::*;
(
    input  logic [ROWS*PSUM_W-1:0]   rows,
    output logic signed [TERM_W-1:0] sum
);
    logic signed [TERM_W-1:0] wt [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic signed [TERM_W-1:0] mag;
        assign mag = signed'({{(TERM_W-PSUM_W){1'b0}}, rows[r*PSUM_W +: PSUM_W]}) <<< r;
        if (r == ROWS-1) begin : g_neg
            assign wt[r] = -mag;
        end else begin : g_pos
            assign wt[r] = mag;
        end
    end

    always_comb begin
        sum = '0;
        for (int r = 0; r < ROWS; r++) begin
            sum = sum + wt[r];
        end
    end
endmodule

// File: rtl/sa_range_shifter.sv
module sa_range_shifter
    import sa_acc_pkg::*;
(
    input  logic [HE_W-1:0]          code,
    input  logic [SHIFT_W-1:0]       shift,
    output logic signed [TERM_W-1:0] sum
);
    assign sum = signed'({{(TERM_W-HE_W){1'b0}}, code} << shift);
endmodule

// File: rtl/sa_cycle_accum.sv
module sa_cycle_accum
    import sa_acc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     beat,
    input  logic signed [TERM_W-1:0] cycle_sum,
    output logic                     busy,
    output logic                     done,
    output logic signed [ACC_W-1:0]  result
);
    logic [CNT_W-1:0]        cnt;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] weighted;
    logic signed [ACC_W-1:0] acc_next;

    assign ext = {{(ACC_W-TERM_W){cycle_sum[TERM_W-1]}}, cycle_sum};

    always_comb begin
        weighted = ext <<< cnt;
        if (cnt == CNT_W'(CYCLES-1)) begin
            weighted = -weighted;
        end
        acc_next = acc + weighted;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            cnt    <= '0;
            acc    <= '0;
            result <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
                acc  <= '0;
            end else if (beat) begin
                if (cnt == CNT_W'(CYCLES-1)) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    result <= acc_next;
                    cnt    <= '0;
                    acc    <= '0;
                end else begin
                    acc <= acc_next;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sa_dual_acc.sv
module sa_dual_acc
    import sa_acc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     mode_sel,
    input  logic [SHIFT_W-1:0]       range_shift,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [ROWS*PSUM_W-1:0]   row_psum,
    input  logic [HE_W-1:0]          conv_psum,
    output logic                     out_valid,
    output logic signed [ACC_W-1:0]  out_result
);
    acc_cfg_t                 cfg_q;
    logic signed [TERM_W-1:0] hp_sum;
    logic signed [TERM_W-1:0] he_sum;
    logic signed [TERM_W-1:0] cycle_sum;
    logic                     busy;
    logic                     beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: MODE_PRECISE, shift: '0};
        end else if (start) begin
            cfg_q <= '{mode: acc_mode_e'(mode_sel), shift: range_shift};
        end
    end

    sa_row_combiner u_rows (
        .rows (row_psum),
        .sum  (hp_sum)
    );

    sa_range_shifter u_range (
        .code  (conv_psum),
        .shift (cfg_q.shift),
        .sum   (he_sum)
    );

    assign cycle_sum = (cfg_q.mode == MODE_EFFICIENT) ? he_sum : hp_sum;
    assign beat      = in_valid && busy;
    assign in_ready  = busy;

    sa_cycle_accum u_acc (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .beat      (beat),
        .cycle_sum (cycle_sum),
        .busy      (busy),
        .done      (out_valid),
        .result    (out_result)
    );
endmodule

// File: rtl/sa_acc_checker.sv
module sa_acc_checker
    import sa_acc_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic signed [ACC_W-1:0] out_result
);
    localparam longint HP_BOUND = ((longint'(1) << PSUM_W) - 1) * ((longint'(1) << ROWS) - 1)
                                  * ((longint'(1) << CYCLES) - 1);
    localparam longint HE_BOUND = ((longint'(1) << HE_W) - 1) * (longint'(1) << ((1 << SHIFT_W) - 1))
                                  * ((longint'(1) << CYCLES) - 1);
    localparam longint BOUND    = (HP_BOUND > HE_BOUND) ? HP_BOUND : HE_BOUND;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !in_ready && out_result == '0));

    assert_ready_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> in_ready);

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_idle_on_done_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid && !start) |=> (in_ready && !out_valid));

    assert_result_held_R11: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_result));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (longint'(out_result) <= BOUND && longint'(out_result) >= -BOUND));
endmodule

bind sa_dual_acc sa_acc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/sim_sa_dual_acc.sv
module sim_sa_dual_acc;
    import sa_acc_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    start = 1'b0;
    logic                    mode_sel = 1'b0;
    logic [SHIFT_W-1:0]      range_shift = '0;
    logic                    in_valid = 1'b0;
    logic                    in_ready;
    logic [ROWS*PSUM_W-1:0]  row_psum = '0;
    logic [HE_W-1:0]         conv_psum = '0;
    logic                    out_valid;
    logic signed [ACC_W-1:0] out_result;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int p [CYCLES][ROWS];
    int cv [CYCLES];
    int unsigned seed = 32'h1234_5678;

    always #4 clk = ~clk;

    sa_dual_acc u0 (
        .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel),
        .range_shift(range_shift), .in_valid(in_valid), .in_ready(in_ready),
        .row_psum(row_psum), .conv_psum(conv_psum),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed >> 8;
    endfunction

    function automatic longint expect_val(input bit m, input int s);
        longint total = 0;
        for (int c = 0; c < CYCLES; c++) begin
            longint cs = 0;
            if (m) cs = longint'(cv[c]) << s;
            else
                for (int r = 0; r < ROWS; r++)
                    cs += ((r == ROWS-1) ? -1 : 1) * (longint'(p[c][r]) << r);
            total += ((c == CYCLES-1) ? -1 : 1) * (cs << c);
        end
        return total;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_beat(input int c);
        in_valid = 1'b1;
        for (int r = 0; r < ROWS; r++) row_psum[r*PSUM_W +: PSUM_W] = PSUM_W'(p[c][r]);
        conv_psum = HE_W'(cv[c]);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic open_op(input bit m, input int s);
        start = 1'b1; mode_sel = m; range_shift = SHIFT_W'(s);
        in_valid = 1'b1;              // offered in start cycle: must be ignored (R2)
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        check(in_ready == 1'b1, "R2 ready after start", in_ready, 1);
    endtask

    task automatic run_op(input bit m, input int s, input bit stall, input bit flip, input string tag);
        longint exp = expect_val(m, s);
        open_op(m, s);
        if (flip) begin mode_sel = ~m; range_shift = ~SHIFT_W'(s); end   // R8
        for (int c = 0; c < CYCLES; c++) begin
            drive_beat(c);
            if (stall && c < CYCLES-1) begin
                @(negedge clk);
                check(!out_valid && in_ready, "R7 stall", out_valid, 0);
            end
        end
        check(out_valid == 1'b1, {tag, " R6 valid"}, out_valid, 1);
        check(longint'(out_result) == exp, tag, longint'(out_result), exp);
        check(!in_ready, "R6 ready low at done", in_ready, 0);
        @(negedge clk);
        check(!out_valid, "R6 one-cycle pulse", out_valid, 0);
    endtask

    task automatic fill_hp_rand();
        for (int c = 0; c < CYCLES; c++)
            for (int r = 0; r < ROWS; r++) p[c][r] = int'(rnd() % 512);
    endtask

    task automatic fill_he_rand();
        for (int c = 0; c < CYCLES; c++) cv[c] = int'(rnd() % 128);
    endtask

    task automatic clear_pat();
        for (int c = 0; c < CYCLES; c++) begin
            cv[c] = 0;
            for (int r = 0; r < ROWS; r++) p[c][r] = 0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        longint held;
        @(negedge clk); @(negedge clk);
        check(!out_valid && !in_ready && out_result == 0, "R1 reset state", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !in_ready && out_result == 0, "R1 after reset", out_result, 0);

        // R4: isolate each cycle and row weight in precise mode
        for (int c = 0; c < CYCLES; c++)
            for (int r = 0; r < ROWS; r++) begin
                clear_pat(); p[c][r] = 1;
                run_op(1'b0, 0, 1'b0, 1'b0, "R4 single term");
            end
        // R3: precise sweep
        for (int i = 0; i < 200; i++) begin
            fill_hp_rand();
            run_op(1'b0, 0, i % 7 == 0, 1'b0, "R3 precise");
        end
        // R5: efficient sweep over every shift
        for (int s = 0; s < (1 << SHIFT_W); s++)
            for (int i = 0; i < 20; i++) begin
                fill_he_rand();
                run_op(1'b1, s, i % 5 == 0, 1'b0, "R5 efficient");
            end
        // R10: extremes
        clear_pat();
        for (int c = 0; c < CYCLES; c++) for (int r = 0; r < ROWS; r++) p[c][r] = 511;
        run_op(1'b0, 0, 1'b0, 1'b0, "R10 precise all max");
        clear_pat(); p[CYCLES-1][ROWS-1] = 511;
        run_op(1'b0, 0, 1'b0, 1'b0, "R10 precise positive corner");
        clear_pat(); cv[CYCLES-1] = 127;
        run_op(1'b1, 7, 1'b0, 1'b0, "R10 efficient most negative");
        clear_pat(); for (int c = 0; c < CYCLES-1; c++) cv[c] = 127;
        run_op(1'b1, 7, 1'b0, 1'b0, "R10 efficient most positive");
        // R8: configuration flipped mid-operation
        for (int i = 0; i < 16; i++) begin
            fill_hp_rand(); fill_he_rand();
            run_op(i[0], i % 8, 1'b0, 1'b1, "R8 config ignored");
        end
        // R9: restart discards earlier beats
        for (int i = 0; i < 8; i++) begin
            fill_hp_rand();
            open_op(1'b0, 0);
            drive_beat(0); drive_beat(1);
            check(!out_valid, "R9 no early result", out_valid, 0);
            fill_he_rand();
            run_op(1'b1, 3, 1'b0, 1'b0, "R9 restart");
        end
        // R11: beats while idle are ignored
        held = longint'(out_result);
        fill_hp_rand();
        for (int k = 0; k < 6; k++) begin
            drive_beat(k % CYCLES);
            check(!out_valid && longint'(out_result) == held, "R11 idle beat ignored",
                  longint'(out_result), held);
        end
        fill_hp_rand();
        run_op(1'b0, 0, 1'b0, 1'b0, "R11 next op clean");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule